// File: doc/BRIEF.md
# GPIO register bank with set/clear aliases

This block is the register side of a 32-pin general-purpose I/O port. It holds three writable registers: a direction register, an output-level register and an interrupt-enable register. It also holds a read-only register that captures the pad levels. Software reaches all of them over a plain synchronous bus that has valid, write, word-address and data lines. Reads are combinational from the address. Writes take effect on the rising clock edge where `bus_valid` and `bus_write` are both high.

The output-level and interrupt-enable registers each have two extra addresses. A write to the set address turns on the bits written as 1. A write to the clear address turns off the bits written as 1. In both cases bits written as 0 keep their value, so one write changes chosen pins with no read-modify-write sequence.

The direction register only steers the pads. A direction bit of 1 makes the pin an input. A bit of 0 enables the pad driver, which then drives the matching output-level bit. Pad levels pass through a two-flop synchronizer into the read-only input register.

Top module: `gpio_bank`

Word-address map: 0 direction, 1 output level, 2 output-level set, 3 output-level clear, 4 interrupt enable, 5 interrupt-enable set, 6 interrupt-enable clear, 7 pad input. Addresses 8 to 15 are unmapped.

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge loads the direction register with all ones and clears the output-level and interrupt-enable registers. After reset, therefore, every pad driver is off.
- R2: An accepted write to address 0, 1 or 4 loads the whole word into the direction, output-level or interrupt-enable register, and a later read of that address returns it.
- R3: An accepted write to address 2 or 5 ORs the data into the output-level or interrupt-enable register. For example, a register holding 0x0000_0100 that receives 0x0000_800E on its set address reads back 0x0000_810E.
- R4: An accepted write to address 3 or 6 clears, in the output-level or interrupt-enable register, every bit written as 1. All other bits of that register keep their value.
- R5: A read of a set or clear address (2, 3, 5 or 6) returns the current value of the register behind it.
- R6: The pad-input register (address 7) is read-only. A write to address 7 changes no register.
- R7: The pad-input register is loaded through two flops. A change on `pad_in` set up before rising edge k is returned by a read of address 7 after edge k+1, and not after edge k alone.
- R8: `pad_out` equals the output-level register, and each bit of `pad_drv_en` is the inverse of the matching direction bit.
- R9: A write with `bus_valid` low changes nothing. A write to an unmapped address (8 to 15) changes nothing, and a read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_drv_en | output | 32 | Pad driver enable, 1 = drive |

## Verification
The hardest case to hit from the ports is the exact latency of the input capture. The bench has to show both that a pad change is still invisible after one edge and that it is visible after the second. It changes `pad_in` on a falling edge, holds a read of address 7, and samples at the next two falling edges. The alias behaviour is swept as well. Every address is written with a range of dense and sparse words, every register is read back after each write, and the result is compared against an arithmetic model. Because the sweep runs from accumulated register contents, a set or clear always meets a register that already holds a mix of ones and zeros.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_ADDR_W = 4;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        SEL_DIR      = 4'd0,
        SEL_LVL      = 4'd1,
        SEL_LVL_SET  = 4'd2,
        SEL_LVL_CLR  = 4'd3,
        SEL_IEN      = 4'd4,
        SEL_IEN_SET  = 4'd5,
        SEL_IEN_CLR  = 4'd6,
        SEL_PADS     = 4'd7
    } reg_sel_e;

    typedef struct packed {
        logic dir_ld;
        logic lvl_ld;
        logic lvl_set;
        logic lvl_clr;
        logic ien_ld;
        logic ien_set;
        logic ien_clr;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_bank_pkg::*;
(
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    output wr_strobe_t             strobe
);

    logic accept;

    assign accept = bus_valid && bus_write;

    always_comb begin
        strobe = '0;
        if (accept) begin
            unique case (bus_addr)
                SEL_DIR:     strobe.dir_ld  = 1'b1;
                SEL_LVL:     strobe.lvl_ld  = 1'b1;
                SEL_LVL_SET: strobe.lvl_set = 1'b1;
                SEL_LVL_CLR: strobe.lvl_clr = 1'b1;
                SEL_IEN:     strobe.ien_ld  = 1'b1;
                SEL_IEN_SET: strobe.ien_set = 1'b1;
                SEL_IEN_CLR: strobe.ien_clr = 1'b1;
                default:     strobe = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] next_q;

    always_comb begin
        next_q = q;
        if (ld) begin
            next_q = wdata;
        end else if (set) begin
            next_q = q | wdata;
        end else if (clr) begin
            next_q = q & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= next_q;
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]       bus_wdata,
    output logic [WIDTH-1:0]       bus_rdata,
    input  logic [WIDTH-1:0]       pad_in,
    output logic [WIDTH-1:0]       pad_out,
    output logic [WIDTH-1:0]       pad_drv_en
);

    localparam logic [WIDTH-1:0] DIR_RESET = '1;
    localparam logic [WIDTH-1:0] ZERO_WORD = '0;

    wr_strobe_t       strobe;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lvl_q;
    logic [WIDTH-1:0] ien_q;
    logic [WIDTH-1:0] din_q;

    gpio_decode u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .strobe    (strobe)
    );

    gpio_alias_reg #(.W(WIDTH), .RESET_VAL(DIR_RESET)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (strobe.dir_ld),
        .set   (1'b0),
        .clr   (1'b0),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    gpio_alias_reg #(.W(WIDTH), .RESET_VAL(ZERO_WORD)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (strobe.lvl_ld),
        .set   (strobe.lvl_set),
        .clr   (strobe.lvl_clr),
        .wdata (bus_wdata),
        .q     (lvl_q)
    );

    gpio_alias_reg #(.W(WIDTH), .RESET_VAL(ZERO_WORD)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (strobe.ien_ld),
        .set   (strobe.ien_set),
        .clr   (strobe.ien_clr),
        .wdata (bus_wdata),
        .q     (ien_q)
    );

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (din_q)
    );

    always_comb begin
        unique case (bus_addr)
            SEL_DIR:                            bus_rdata = dir_q;
            SEL_LVL, SEL_LVL_SET, SEL_LVL_CLR:  bus_rdata = lvl_q;
            SEL_IEN, SEL_IEN_SET, SEL_IEN_CLR:  bus_rdata = ien_q;
            SEL_PADS:                           bus_rdata = din_q;
            default:                            bus_rdata = '0;
        endcase
    end

    assign pad_out    = lvl_q;
    assign pad_drv_en = ~dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [GPIO_ADDR_W-1:0] bus_addr,
    input logic [W-1:0]           bus_wdata,
    input logic [W-1:0]           pad_in,
    input logic [W-1:0]           pad_drv_en,
    input logic [W-1:0]           dir_q,
    input logic [W-1:0]           lvl_q,
    input logic [W-1:0]           ien_q,
    input logic [W-1:0]           din_q
);

    logic rst_seen_q;
    logic wr_ok;

    assign wr_ok = bus_valid && bus_write;

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_n && rst_seen_q) begin
            assert_reset_values_R1: assert (dir_q == '1 && lvl_q == '0 && ien_q == '0)
                else $error("R1 reset values wrong");
        end
    end

    assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == SEL_LVL_SET) |=> lvl_q == ($past(lvl_q) | $past(bus_wdata)));

    assert_ien_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == SEL_IEN_SET) |=> ien_q == ($past(ien_q) | $past(bus_wdata)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == SEL_LVL_CLR) |=> lvl_q == ($past(lvl_q) & ~$past(bus_wdata)));

    assert_pads_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == SEL_PADS) |=> ($stable(dir_q) && $stable(lvl_q) && $stable(ien_q)));

    assert_drv_follows_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == SEL_DIR) |=> pad_drv_en == ~$past(bus_wdata));

    assert_invalid_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid) |=> ($stable(dir_q) && $stable(lvl_q) && $stable(ien_q)));

    if (SYNC_STAGES == 2) begin : g_lat
        assert_capture_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rst_seen_q == 1'b0 |-> din_q == $past(pad_in, 2));
    end

endmodule

bind gpio_bank gpio_bank_chk #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_in     (pad_in),
    .pad_drv_en (pad_drv_en),
    .dir_q      (dir_q),
    .lvl_q      (lvl_q),
    .ien_q      (ien_q),
    .din_q      (din_q)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in = 32'h1357_9BDF;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_drv_en;

    int n_vec = 0;
    int n_bad = 0;
    logic [W-1:0] dir_m, lvl_m, ien_m, din_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_drv_en (pad_drv_en)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [W-1:0] d, input logic v);
        @(negedge clk);
        bus_valid = v; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (v) begin
            case (a)
                4'd0: dir_m = d;
                4'd1: lvl_m = d;
                4'd2: lvl_m = lvl_m | d;
                4'd3: lvl_m = lvl_m & ~d;
                4'd4: ien_m = d;
                4'd5: ien_m = ien_m | d;
                4'd6: ien_m = ien_m & ~d;
                default: ;
            endcase
        end
    endtask

    function automatic logic [W-1:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return dir_m;
            4'd1, 4'd2, 4'd3: return lvl_m;
            4'd4, 4'd5, 4'd6: return ien_m;
            4'd7: return din_m;
            default: return '0;
        endcase
    endfunction

    function automatic string wr_tag(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd4: return "R2";
            4'd2, 4'd5: return "R3";
            4'd3, 4'd6: return "R4";
            4'd7: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic read_check(input logic [3:0] a, input string req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(bus_rdata, exp_read(a), req);
        bus_valid = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) begin
            if (a == 2 || a == 3 || a == 5 || a == 6) read_check(4'(a), "R5");
            else read_check(4'(a), req);
        end
        check(pad_out, lvl_m, "R8");
        check(pad_drv_en, ~dir_m, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        dir_m = '1; lvl_m = '0; ien_m = '0; din_m = pad_in;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        read_check(4'd0, "R1");
        read_check(4'd1, "R1");
        read_check(4'd4, "R1");
        check(pad_drv_en, '0, "R1");

        // R3: worked example on output level and interrupt enable
        do_write(4'd1, 32'h0000_0100, 1'b1);
        do_write(4'd2, 32'h0000_800E, 1'b1);
        check(lvl_m, 32'h0000_810E, "R3");
        read_check(4'd1, "R3");
        do_write(4'd4, 32'h0000_0100, 1'b1);
        do_write(4'd5, 32'h0000_800E, 1'b1);
        read_check(4'd4, "R3");

        // R9: writes with valid low
        do_write(4'd1, 32'hFFFF_FFFF, 1'b0);
        do_write(4'd0, 32'h0000_0000, 1'b0);
        read_all("R9");

        // Sweep all addresses with several patterns
        for (int p = 0; p < 10; p++) begin
            logic [W-1:0] pat;
            case (p)
                0: pat = 32'hFFFF_FFFF;
                1: pat = 32'h0000_0000;
                2: pat = 32'hA5A5_A5A5;
                3: pat = 32'h5A5A_5A5A;
                default: pat = (32'h9E37_79B9 * (p + 1)) ^ (32'h1 << (p * 3));
            endcase
            for (int a = 0; a < 16; a++) begin
                do_write(4'(a), pat ^ (32'h0101_0101 * a), 1'b1);
                read_all(wr_tag(4'(a)));
            end
        end

        // R7: capture latency
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] nv;
            nv = ~din_m ^ (32'h0F0F_0000 >> k);
            @(negedge clk);
            pad_in = nv;
            bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd7;
            @(negedge clk);
            #1;
            check(bus_rdata, din_m, "R7 one edge");
            @(negedge clk);
            #1;
            din_m = nv;
            check(bus_rdata, din_m, "R7 two edges");
            bus_valid = 1'b0;
        end

        // R6: write to pad register ignored
        do_write(4'd7, ~din_m, 1'b1);
        read_all("R6");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule